// File: doc/BRIEF.md
# Word-Clock Lock Monitor

This block tells a serial transmitter whether its fast bit clock is locked to the incoming parallel word clock. A counter divides the fast clock by ten to make an internal word clock, which is also driven out as a monitor pin. The reference word clock arrives as a plain digital input. It passes through a synchroniser and is then sampled once per internal word period, at the edge where the internal word clock rises. When the two clocks are in phase, the reference reads high at every sample.

The raw samples are filtered. Lock is declared after a long run of high samples and withdrawn after a short run of low ones, so the status does not chatter. The status gates the differential serial output: while unlocked, the output pair is parked in a fixed idle state. A free-run test input blocks the reference and forces the unlocked state. The divider keeps running in test mode, so the monitor pin still shows the free-running rate.

Top module: `clk_lock_monitor`

## Requirements
- R1: While reset is held and on release, the divide counter is zero, `word_clk_mon` is high and `lock_ok` is low.
- R2: `word_clk_mon` repeats every 10 fast-clock cycles, high for 5 cycles and then low for 5, starting high after reset.
- R3: The reference input passes through two clocked stages before it reaches the sampler, so a level on `ref_clk` takes two fast edges to become visible.
- R4: The synchronised reference is sampled only at the fast edge where `word_clk_mon` goes from low to high (counter wrapping from 9 to 0). Values at other edges have no effect on `lock_ok`.
- R5: `lock_ok` rises at the sample edge that completes 16 consecutive high samples.
- R6: Once locked, a single low sample leaves `lock_ok` high. `lock_ok` falls at the second consecutive low sample.
- R7: Any low sample restarts the count of high samples from zero, even when the count is partway through.
- R8: While `free_run` is high, `lock_ok` is low from the next fast edge on, `ref_clk` is ignored, and both run counters are cleared. After release, a fresh run of 16 high samples is needed.
- R9: While `lock_ok` is low, `ser_p`=1 and `ser_n`=0. While `lock_ok` is high, `ser_p` follows `ser_bit` and `ser_n` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_run | input | 1 | Test mode: blocks the reference and forces unlocked |
| ref_clk | input | 1 | Reference word clock, sampled as data |
| ser_bit | input | 1 | Serial bit to be gated onto the output pair |
| word_clk_mon | output | 1 | Internal divided word clock (monitor) |
| lock_ok | output | 1 | Filtered lock status |
| ser_p | output | 1 | Gated serial output, true side |
| ser_n | output | 1 | Gated serial output, complement side |

## Verification
The hardest state to reach is a partly built high run that is broken by exactly one low sample, whether the block is already locked or still counting up. To hit just one sample edge, the stimulus holds the reference low for one full word period. A clean reference clock is also applied at each of the ten phase offsets relative to the divider. Some offsets lock and others read low at every sample. A behavioural model in the bench, built from a phase integer and a two-entry queue, predicts every output on every cycle.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   typedef enum logic {LK_OFF = 1'b0, LK_ON = 1'b1} lock_state_e;

   function automatic int run_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/clkmon_divider.sv
module clkmon_divider #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic word_clk,
   output logic tick
);
   localparam int CW   = (DIV < 2) ? 1 : $clog2(DIV);
   localparam int HALF = DIV / 2;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("clkmon_divider: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (cnt == CW'(DIV-1))  cnt <= '0;
      else                         cnt <= cnt + CW'(1);
   end

   assign word_clk = (cnt < CW'(HALF));
   assign tick     = (cnt == CW'(DIV-1));

   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(DIV));
   p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_clk) |-> $past(tick));
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkmon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_filter.sv
module clkmon_filter
   import clkmon_pkg::*;
#(
   parameter int ON_RUN  = 16,
   parameter int OFF_RUN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_off,
   input  logic tick,
   input  logic sample,
   output logic lock
);
   localparam int HW = run_width(ON_RUN);
   localparam int LW = run_width(OFF_RUN);

   generate
      if (ON_RUN < 1 || OFF_RUN < 1) begin : g_bad_runs
         $error("clkmon_filter: run lengths must be at least 1");
      end
   endgenerate

   logic [HW-1:0] hi_run;
   logic [LW-1:0] lo_run;
   lock_state_e   state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
         state  <= LK_OFF;
      end else if (force_off) begin
         hi_run <= '0;
         lo_run <= '0;
         state  <= LK_OFF;
      end else if (tick) begin
         if (sample) begin
            lo_run <= '0;
            if (hi_run != HW'(ON_RUN)) hi_run <= hi_run + HW'(1);
            if (hi_run >= HW'(ON_RUN-1)) state <= LK_ON;
         end else begin
            hi_run <= '0;
            if (lo_run != LW'(OFF_RUN)) lo_run <= lo_run + LW'(1);
            if (lo_run >= LW'(OFF_RUN-1)) state <= LK_OFF;
         end
      end
   end

   assign lock = (state == LK_ON);

   p_rise_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> ($past(tick) && $past(sample) && !$past(force_off)));
   p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !force_off) |=> $stable(lock));
   p_force_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (!lock && hi_run == '0 && lo_run == '0));
   p_low_breaks_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sample) |=> (hi_run == '0));

   generate
      if (OFF_RUN > 1) begin : g_hold_chk
         p_single_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (lock && !force_off && tick && !sample && lo_run == '0) |=> lock);
      end
   endgenerate
endmodule

// File: rtl/clk_lock_monitor.sv
module clk_lock_monitor #(
   parameter int DIV         = 10,
   parameter int SYNC_STAGES = 2,
   parameter int ON_RUN      = 16,
   parameter int OFF_RUN     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic free_run,
   input  logic ref_clk,
   input  logic ser_bit,
   output logic word_clk_mon,
   output logic lock_ok,
   output logic ser_p,
   output logic ser_n
);
   logic tick;
   logic ref_gated;
   logic ref_sync;

   assign ref_gated = ref_clk & ~free_run;

   clkmon_divider #(.DIV(DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_clk (word_clk_mon),
      .tick     (tick)
   );

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ref_gated),
      .q     (ref_sync)
   );

   clkmon_filter #(.ON_RUN(ON_RUN), .OFF_RUN(OFF_RUN)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_off (free_run),
      .tick      (tick),
      .sample    (ref_sync),
      .lock      (lock_ok)
   );

   assign ser_p = lock_ok ? ser_bit  : 1'b1;
   assign ser_n = lock_ok ? ~ser_bit : 1'b0;

   p_idle_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_ok |-> (ser_p && !ser_n));
   p_pair_complement_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ser_p != ser_n);
   p_test_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      free_run |=> !lock_ok);
endmodule

// File: tb/clk_lock_monitor_test.sv
`timescale 1ns/1ps
module clk_lock_monitor_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic free_run = 1'b0;
   logic ref_clk = 1'b1;
   logic ser_bit = 1'b0;
   logic word_clk_mon, lock_ok, ser_p, ser_n;

   int vectors = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clk_lock_monitor uut (
      .clk(clk), .rst_n(rst_n), .free_run(free_run), .ref_clk(ref_clk),
      .ser_bit(ser_bit), .word_clk_mon(word_clk_mon), .lock_ok(lock_ok),
      .ser_p(ser_p), .ser_n(ser_n)
   );

   // behavioural reference model
   int m_phase = 0;
   int m_hi = 0;
   int m_lo = 0;
   bit m_lock = 1'b0;
   bit m_sq[$] = '{1'b0, 1'b0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_hi = 0; m_lo = 0; m_lock = 1'b0;
         m_sq = '{1'b0, 1'b0};
      end else begin
         bit smp;
         smp = m_sq[0];
         if (free_run) begin
            m_hi = 0; m_lo = 0; m_lock = 1'b0;
         end else if (m_phase == 9) begin
            if (smp) begin
               m_lo = 0;
               if (m_hi < 16) m_hi++;
               if (m_hi >= 16) m_lock = 1'b1;
            end else begin
               m_hi = 0;
               if (m_lo < 2) m_lo++;
               if (m_lo >= 2) m_lock = 1'b0;
            end
         end
         void'(m_sq.pop_front());
         m_sq.push_back(ref_clk & ~free_run);
         m_phase = (m_phase + 1) % 10;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_p;
         exp_p = m_lock ? ser_bit : 1'b1;
         check("R2 word_clk_mon model", word_clk_mon, (m_phase < 5) ? 1 : 0);
         check("R5 lock_ok model", lock_ok, m_lock);
         check("R9 ser_p model", ser_p, exp_p);
         check("R9 ser_n model", ser_n, m_lock ? !ser_bit : 0);
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      vectors++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int highs;
      int held;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 lock_ok in reset", lock_ok, 0);
      check("R1 word_clk_mon in reset", word_clk_mon, 1);
      check("R9 ser_p idle", ser_p, 1);
      check("R9 ser_n idle", ser_n, 0);
      rst_n = 1'b1;

      // R2: five highs in ten cycles
      highs = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         highs += word_clk_mon;
      end
      check("R2 duty highs per period", highs, 5);

      // R3 R5: ref held high since reset; 16th sample lands on edge 160
      repeat (145) @(negedge clk);
      check("R5 no lock after 15 samples (R3 delay)", lock_ok, 0);
      repeat (10) @(negedge clk);
      check("R5 lock after 16 samples", lock_ok, 1);

      // R9: data passes while locked
      ser_bit = 1'b1; #0.5;
      check("R9 ser_p follows 1", ser_p, 1);
      check("R9 ser_n complements 1", ser_n, 0);
      ser_bit = 1'b0; #0.5;
      check("R9 ser_p follows 0", ser_p, 0);
      check("R9 ser_n complements 0", ser_n, 1);

      // R6: exactly one low sample keeps lock
      ref_clk = 1'b0;
      repeat (10) @(negedge clk);
      ref_clk = 1'b1;
      held = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!lock_ok) held = 0;
      end
      check("R6 single low sample ignored", held, 1);
      ref_clk = 1'b0;
      repeat (30) @(negedge clk);
      check("R6 two low samples unlock", lock_ok, 0);

      // R7: broken run restarts count
      ref_clk = 1'b1;
      repeat (100) @(negedge clk);
      ref_clk = 1'b0;
      repeat (10) @(negedge clk);
      ref_clk = 1'b1;
      repeat (100) @(negedge clk);
      check("R7 run restarted after low", lock_ok, 0);
      repeat (100) @(negedge clk);
      check("R7 lock after fresh run", lock_ok, 1);

      // R8: test mode
      free_run = 1'b1;
      @(negedge clk);
      check("R8 lock drops next edge", lock_ok, 0);
      check("R9 ser_p idle in test", ser_p, 1);
      held = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (lock_ok) held = 1;
      end
      check("R8 reference ignored in test", held, 0);
      free_run = 1'b0;
      repeat (150) @(negedge clk);
      check("R8 counters cleared by test", lock_ok, 0);
      repeat (30) @(negedge clk);
      check("R8 relock after release", lock_ok, 1);

      // R4: clean reference at each phase offset, checked against model
      for (int k = 0; k < 10; k++) begin
         for (int p = 0; p < 25; p++) begin
            for (int j = 0; j < 10; j++) begin
               ref_clk = (((j + k) % 10) < 5);
               @(negedge clk);
            end
         end
         check("R4 lock per phase offset", lock_ok, m_lock);
      end

      // irregular reference
      for (int i = 0; i < 600; i++) begin
         if ((i * 7 + i / 13) % 11 < 3) ref_clk = ~ref_clk;
         ser_bit = i[2];
         @(negedge clk);
      end
      finish_run();
   end
endmodule